// File: doc/BRIEF.md
# Three-Term Lifting Step Arithmetic Core

This block evaluates one integer lifting filter step of the shape W = X + Ci·Y + Cj·Z. The three data operands are signed 10-bit samples. The two coefficients are small signed integers that have already been scaled up by a power of two. Each coefficient is multiplied with its data operand in a radix-4 Booth multiplier. Each product is brought back to sample scale by an arithmetic right shift, truncated to the sample width, and added to X in a three-input adder that wraps at the sample width.

A sequencer outside the block presents the operands together with a valid strobe. Any lifting step maps onto this one form. When a step has only one neighbour term, the sequencer sets the unused coefficient to zero, and a pass-through of X is obtained with both coefficients at zero. The result is registered once, so it appears one clock after the strobe and stays put until the next strobe.

Top module: `lift_step_core`

## Requirements
- R1: X, Y and Z are 10-bit two's-complement values (-512..511), and Ci and Cj are 6-bit two's-complement values (-32..31). All signed values are accepted without restriction.
- R2: The result equals (X + T(Ci·Y) + T(Cj·Z)) mod 2^10 in two's complement. T(p) takes the 16-bit product p, shifts it right arithmetically by 3 bits, and keeps the low 10 bits.
- R3: A result computed from the operands sampled with in_valid high appears on w_out, with out_valid high, on the clock edge after that sample. Back-to-back strobes give back-to-back results.
- R4: On a cycle after an edge with in_valid low, out_valid is low and w_out keeps its previous value, whatever the operand inputs do.
- R5: While rst_n is low, out_valid and w_out are both zero.
- R6: With Cj = 0 the result is X + T(Ci·Y). With both coefficients at zero the result is X.
- R7: A sum that leaves the 10-bit range wraps and does not saturate. For example, 511 + 1 gives -512 and -512 - 1 gives 511.
- R8: A negative product is shifted toward minus infinity, so Ci = -1 and Y = 1 contribute -1 and not 0.
- R9: Extreme products are truncated after the shift. Ci = -32 with Y = -512 contributes 0. Ci = 31 with Y = 511 contributes -68. Ci = -32 with Y = 511 contributes 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| x_in | input | 10 | Signed base operand X |
| y_in | input | 10 | Signed operand Y, scaled by Ci |
| z_in | input | 10 | Signed operand Z, scaled by Cj |
| ci_in | input | 6 | Signed scaled coefficient Ci |
| cj_in | input | 6 | Signed scaled coefficient Cj |
| out_valid | output | 1 | w_out was updated on this edge |
| w_out | output | 10 | Signed wrapped result W |

## Verification
Every arithmetic result passes through exactly one register. The result and its strobe are therefore due on the first rising edge after the operands are presented with in_valid high. The bench drives operands on a falling edge and checks w_out and out_valid on the next falling edge, half a cycle after that capture. For an idle cycle, it changes the operands with in_valid low, waits one edge in the same way, and confirms that out_valid is low and that w_out still shows the previous result.

// File: rtl/lift_pkg.sv
package lift_pkg;
  localparam int unsigned DATA_W  = 10;
  localparam int unsigned COEF_W  = 6;
  localparam int unsigned SCALE_SH = 3;
  localparam int unsigned PROD_W  = DATA_W + COEF_W;

  typedef logic signed [DATA_W-1:0] sample_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [PROD_W-1:0] prod_t;
endpackage

// File: rtl/lift_booth_mul.sv
module lift_booth_mul #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned COEF_W = 6,
  localparam int unsigned PROD_W = DATA_W + COEF_W,
  localparam int unsigned NUM_PP = COEF_W / 2
) (
  input  logic signed [DATA_W-1:0] data_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [PROD_W-1:0] prod_o
);
  // coefficient with an implicit zero below bit 0 for the first digit
  logic [COEF_W:0]                 coef_pad;
  logic signed [PROD_W-1:0]        data_ext;
  logic signed [PROD_W-1:0]        pp [NUM_PP];

  assign coef_pad = {coef_i, 1'b0};
  assign data_ext = {{(PROD_W-DATA_W){data_i[DATA_W-1]}}, data_i};

  for (genvar k = 0; k < NUM_PP; k++) begin : g_pp
    logic [2:0]               trip;
    logic signed [PROD_W-1:0] mag;
    assign trip = coef_pad[2*k+2 : 2*k];
    always_comb begin
      case (trip)
        3'b001, 3'b010: mag = data_ext;
        3'b011:         mag = data_ext <<< 1;
        3'b100:         mag = -(data_ext <<< 1);
        3'b101, 3'b110: mag = -data_ext;
        default:        mag = '0;
      endcase
    end
    assign pp[k] = mag <<< (2*k);
  end

  always_comb begin
    prod_o = '0;
    for (int k = 0; k < NUM_PP; k++) begin
      prod_o = prod_o + pp[k];
    end
  end
endmodule

// File: rtl/lift_scale_trunc.sv
module lift_scale_trunc #(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned PROD_W   = 16,
  parameter int unsigned SCALE_SH = 3
) (
  input  logic signed [PROD_W-1:0] prod_i,
  output logic signed [DATA_W-1:0] trunc_o
);
  localparam int unsigned TOP_LSB = SCALE_SH + DATA_W;

  // arithmetic shift then truncation is a bit slice of the product
  assign trunc_o = prod_i[TOP_LSB-1 : SCALE_SH];

  if (SCALE_SH > 0) begin : g_low_drop
    logic unused_low;
    assign unused_low = ^prod_i[SCALE_SH-1:0];
  end
  if (TOP_LSB < PROD_W) begin : g_high_drop
    logic unused_high;
    assign unused_high = ^prod_i[PROD_W-1:TOP_LSB];
  end
endmodule

// File: rtl/lift_add3.sv
module lift_add3 #(
  parameter int unsigned DATA_W = 10
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic signed [DATA_W-1:0] c_i,
  output logic signed [DATA_W-1:0] sum_o
);
  // modulo 2^DATA_W: carries beyond the width are discarded
  always_comb begin
    sum_o = a_i + b_i + c_i;
  end
endmodule

// File: rtl/lift_step_core.sv
module lift_step_core
  import lift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] z_in,
  input  logic [COEF_W-1:0] ci_in,
  input  logic [COEF_W-1:0] cj_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] w_out
);
  prod_t   prod_i, prod_j;
  sample_t term_i, term_j, sum_w;
  sample_t res_d, res_q;
  logic    vld_d, vld_q;

  lift_booth_mul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) mul_i_u (
    .data_i(sample_t'(y_in)), .coef_i(coef_t'(ci_in)), .prod_o(prod_i));
  lift_booth_mul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) mul_j_u (
    .data_i(sample_t'(z_in)), .coef_i(coef_t'(cj_in)), .prod_o(prod_j));

  lift_scale_trunc #(.DATA_W(DATA_W), .PROD_W(PROD_W), .SCALE_SH(SCALE_SH)) sc_i_u (
    .prod_i(prod_i), .trunc_o(term_i));
  lift_scale_trunc #(.DATA_W(DATA_W), .PROD_W(PROD_W), .SCALE_SH(SCALE_SH)) sc_j_u (
    .prod_i(prod_j), .trunc_o(term_j));

  lift_add3 #(.DATA_W(DATA_W)) add_u (
    .a_i(sample_t'(x_in)), .b_i(term_i), .c_i(term_j), .sum_o(sum_w));

  // next-state: result register enabled by in_valid
  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? sum_w : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign w_out     = res_q;
endmodule

// File: rtl/lift_step_core_chk.sv
module lift_step_core_chk
  import lift_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] x_in,
  input logic [DATA_W-1:0] y_in,
  input logic [DATA_W-1:0] z_in,
  input logic [COEF_W-1:0] ci_in,
  input logic [COEF_W-1:0] cj_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] w_out
);
  logic signed [PROD_W-1:0] mul_y, mul_z;
  logic [DATA_W-1:0]        ref_w;

  always_comb begin
    mul_y = PROD_W'($signed(ci_in)) * PROD_W'($signed(y_in));
    mul_z = PROD_W'($signed(cj_in)) * PROD_W'($signed(z_in));
    ref_w = x_in + DATA_W'(mul_y >>> SCALE_SH) + DATA_W'(mul_z >>> SCALE_SH);
  end

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(w_out));
  // R2
  sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (w_out == $past(ref_w)));
  // R6
  pass_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ci_in == '0 && cj_in == '0) |=> (w_out == $past(x_in)));
endmodule

bind lift_step_core lift_step_core_chk chk_u (.*);

// File: tb/lift_step_core_tb.sv
`timescale 1ns/1ps
module lift_step_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [9:0] x_in, y_in, z_in;
  logic [5:0] ci_in, cj_in;
  logic       out_valid;
  logic [9:0] w_out;
  int         n_chk = 0;
  int         n_err = 0;
  logic [9:0] last_w;

  always #2.5 clk = ~clk;

  lift_step_core dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_in(x_in), .y_in(y_in), .z_in(z_in), .ci_in(ci_in), .cj_in(cj_in),
    .out_valid(out_valid), .w_out(w_out));

  function automatic logic [9:0] model(int x, int y, int z, int ci, int cj);
    int si = (ci * y) >>> 3;
    int sj = (cj * z) >>> 3;
    int s  = x + si + sj;
    return s[9:0];
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d (0x%h) expected=%0d (0x%h)", req,
               $signed(act), act, $signed(exp), exp);
    end
  endtask

  // drive at a falling edge, check one falling edge later (one register)
  task automatic apply(string req, int x, int y, int z, int ci, int cj);
    logic [9:0] e = model(x, y, z, ci, cj);
    x_in = x[9:0]; y_in = y[9:0]; z_in = z[9:0];
    ci_in = ci[5:0]; cj_in = cj[5:0]; in_valid = 1'b1;
    @(negedge clk);
    check({req, " valid"}, {9'd0, out_valid}, 10'd1);
    check(req, w_out, e);
    last_w = e;
  endtask

  task automatic t_reset;
    check("R5 valid", {9'd0, out_valid}, 10'd0);
    check("R5 result", w_out, 10'd0);
  endtask

  task automatic t_basic;
    apply("R2 mixed", 100, 40, -24, 4, -6);     // 100+20+18
    check("R2 const", w_out, 10'd138);
    apply("R1 negatives", -300, -100, 77, 13, -9);
  endtask

  task automatic t_single;
    apply("R6 one term", 7, 50, 300, 8, 0);
    check("R6 one term const", w_out, 10'd57);
    apply("R6 pass x", -200, 123, -45, 0, 0);
    check("R6 pass x const", w_out, 10'(-200));
  endtask

  task automatic t_wrap;
    apply("R7 up", 511, 1, 0, 8, 0);
    check("R7 up const", w_out, 10'h200);
    apply("R7 down", -512, 1, 0, -8, 0);
    check("R7 down const", w_out, 10'h1FF);
  endtask

  task automatic t_floor;
    apply("R8 floor", 0, 1, 1, -1, 1);
    check("R8 floor const", w_out, 10'h3FF);
  endtask

  task automatic t_extreme;
    apply("R9 ext a", 0, -512, 511, -32, 31);
    check("R9 ext a const", w_out, 10'(-68));
    apply("R9 ext b", 0, 511, 0, -32, 0);
    check("R9 ext b const", w_out, 10'd4);
  endtask

  task automatic t_idle;
    x_in = 10'd99; y_in = 10'd3; z_in = 10'd5; ci_in = 6'd7; cj_in = 6'd2;
    in_valid = 1'b0;
    @(negedge clk);
    check("R4 idle valid", {9'd0, out_valid}, 10'd0);
    check("R4 idle hold", w_out, last_w);
    x_in = 10'd1;
    @(negedge clk);
    check("R4 idle hold 2", w_out, last_w);
  endtask

  task automatic t_stream;
    for (int k = 0; k < 6; k++) begin
      apply("R3 stream", 37 * k - 90, 61 - 29 * k, 13 * k, k - 3, 5 - 2 * k);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    x_in = '0; y_in = '0; z_in = '0; ci_in = '0; cj_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_single();
    t_wrap();
    t_floor();
    t_extreme();
    t_idle();
    t_stream();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule